// File: doc/BRIEF.md
# Ping-Pong DMA Buffer Selector

This block keeps the alternation between two external memory buffers, called A and B, for each direction of one DMA channel: one pair for transmit, one pair for receive. Each direction has a next-buffer bit that the DMA engine reads to learn which buffer to fill or drain next. When the engine begins using that buffer, it pulses a start strobe. The block then flips the next-buffer bit so the other buffer is lined up, and it marks the direction busy. A completion strobe from the engine ends the busy period.

A start strobe that arrives while its direction is still busy is refused. The refusal is reported on a one-cycle overrun output so that the surrounding channel logic can react. The host sees the state of both directions through a read-only status byte. Address counters, descriptors and interrupts belong to neighbouring blocks.

Top module: `pingpong_buf_sel`

## Requirements
- R1: While reset is asserted and in the first cycle after it, status is 0x00, both select outputs are 0 (buffer A), and both busy and overrun outputs are 0.
- R2: A select output of 0 names buffer A and 1 names buffer B. A select output changes only in the cycle after an accepted start for its own direction.
- R3: A start strobe while the direction is not busy is accepted. In the next cycle the select output is inverted and busy is 1.
- R4: A done strobe while the direction is busy clears busy in the next cycle and leaves the select output unchanged.
- R5: A start strobe while the direction is busy is ignored, so select and busy keep their values from this start. Overrun is 1 for exactly the following cycle. Overrun is 0 in every other cycle.
- R6: Status bit 3 is the transmit select, bit 2 is transmit busy, bit 1 is the receive select and bit 0 is receive busy. Bits 7:4 always read 0.
- R7: Strobes for one direction never change the select, busy or overrun outputs of the other direction.
- R8: When start and done arrive in the same cycle on a busy direction, busy clears, the select is unchanged and overrun is flagged. On an idle direction the same pair is an accepted start.
- R9: A done strobe on an idle direction has no effect on select, busy or overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_start | input | 1 | Transmit buffer use begins |
| tx_done | input | 1 | Transmit buffer finished |
| rx_start | input | 1 | Receive buffer use begins |
| rx_done | input | 1 | Receive buffer finished |
| tx_sel | output | 1 | Transmit next buffer (0 = A, 1 = B) |
| tx_busy | output | 1 | Transmit buffer in use |
| tx_overrun | output | 1 | Transmit start refused last cycle |
| rx_sel | output | 1 | Receive next buffer (0 = A, 1 = B) |
| rx_busy | output | 1 | Receive buffer in use |
| rx_overrun | output | 1 | Receive start refused last cycle |
| status | output | STATUS_W | Packed read-only status byte |

## Verification
The bench targets four cases:
- A start on a busy direction. A design that toggles anyway would skip a buffer and never raise overrun.
- Start and done together, both on a busy direction and on an idle one. A design that gives done priority in the idle case would leave busy low after a real start.
- A stray done on an idle direction. This must not disturb the pointer.
- Crossed strobes between the two directions, together with the status bit order. These catch a swapped lane or a status field packed in the wrong position.

// File: rtl/pingpong_buf_sel_pkg.sv
package pingpong_buf_sel_pkg;

   // Buffer identity carried by a next-buffer bit.
   typedef enum logic {
      BUF_A = 1'b0,
      BUF_B = 1'b1
   } buf_id_e;

   // Per-direction registered state.
   typedef struct packed {
      logic next_buf;
      logic busy;
   } lane_state_t;

   localparam int unsigned LANE_CNT   = 2;
   localparam int unsigned LANE_RX    = 0;
   localparam int unsigned LANE_TX    = 1;
   localparam int unsigned LANE_BITS  = $bits(lane_state_t);

   localparam lane_state_t LANE_RESET = '{next_buf: BUF_A, busy: 1'b0};

endpackage

// File: rtl/ppb_lane.sv
module ppb_lane
   import pingpong_buf_sel_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic done_i,
   output logic next_o,
   output logic busy_o,
   output logic overrun_o
);

   lane_state_t st_q;
   lane_state_t st_d;
   logic        accept;
   logic        refuse;
   logic        ovr_q;

   assign accept = start_i & ~st_q.busy;
   assign refuse = start_i &  st_q.busy;

   always_comb begin
      st_d = st_q;
      if (accept) begin
         st_d.next_buf = ~st_q.next_buf;
         st_d.busy     = 1'b1;
      end else if (done_i) begin
         st_d.busy     = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= LANE_RESET;
         ovr_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         ovr_q <= refuse;
      end
   end

   assign next_o    = st_q.next_buf;
   assign busy_o    = st_q.busy;
   assign overrun_o = ovr_q;

endmodule

// File: rtl/ppb_status_pack.sv
module ppb_status_pack
   import pingpong_buf_sel_pkg::*;
#(
   parameter int unsigned STATUS_W = 8
)(
   input  logic [LANE_CNT-1:0] next_i,
   input  logic [LANE_CNT-1:0] busy_i,
   output logic [STATUS_W-1:0] status_o
);

   localparam int unsigned USED_W = LANE_CNT * LANE_BITS;

   if (STATUS_W < USED_W) begin : g_width_bad
      $error("ppb_status_pack: STATUS_W too small for packed lanes");
   end

   for (genvar b = 0; b < STATUS_W; b++) begin : g_bit
      if (b < USED_W) begin : g_used
         if (b % 2 == 1) begin : g_next
            assign status_o[b] = next_i[b/2];
         end else begin : g_busy
            assign status_o[b] = busy_i[b/2];
         end
      end else begin : g_zero
         assign status_o[b] = 1'b0;
      end
   end

endmodule

// File: rtl/pingpong_buf_sel.sv
module pingpong_buf_sel
   import pingpong_buf_sel_pkg::*;
#(
   parameter int unsigned STATUS_W = 8
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tx_start,
   input  logic                tx_done,
   input  logic                rx_start,
   input  logic                rx_done,
   output logic                tx_sel,
   output logic                tx_busy,
   output logic                tx_overrun,
   output logic                rx_sel,
   output logic                rx_busy,
   output logic                rx_overrun,
   output logic [STATUS_W-1:0] status
);

   if (STATUS_W < 4 || STATUS_W > 64) begin : g_param_bad
      $error("pingpong_buf_sel: STATUS_W must be within 4..64");
   end

   logic [LANE_CNT-1:0] start_v;
   logic [LANE_CNT-1:0] done_v;
   logic [LANE_CNT-1:0] next_v;
   logic [LANE_CNT-1:0] busy_v;
   logic [LANE_CNT-1:0] ovr_v;

   assign start_v[LANE_RX] = rx_start;
   assign start_v[LANE_TX] = tx_start;
   assign done_v[LANE_RX]  = rx_done;
   assign done_v[LANE_TX]  = tx_done;

   for (genvar i = 0; i < LANE_CNT; i++) begin : g_lane
      ppb_lane u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .start_i   (start_v[i]),
         .done_i    (done_v[i]),
         .next_o    (next_v[i]),
         .busy_o    (busy_v[i]),
         .overrun_o (ovr_v[i])
      );
   end

   ppb_status_pack #(.STATUS_W(STATUS_W)) u_pack (
      .next_i   (next_v),
      .busy_i   (busy_v),
      .status_o (status)
   );

   assign tx_sel     = next_v[LANE_TX];
   assign tx_busy    = busy_v[LANE_TX];
   assign tx_overrun = ovr_v[LANE_TX];
   assign rx_sel     = next_v[LANE_RX];
   assign rx_busy    = busy_v[LANE_RX];
   assign rx_overrun = ovr_v[LANE_RX];

endmodule

// File: rtl/pingpong_buf_sel_chk.sv
module pingpong_buf_sel_chk #(
   parameter int unsigned STATUS_W = 8
)(
   input logic                clk,
   input logic                rst_n,
   input logic                tx_start,
   input logic                tx_done,
   input logic                rx_start,
   input logic                rx_done,
   input logic                tx_sel,
   input logic                tx_busy,
   input logic                tx_overrun,
   input logic                rx_sel,
   input logic                rx_busy,
   input logic                rx_overrun,
   input logic [STATUS_W-1:0] status
);

   assert_tx_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_start && !tx_busy) |=> (tx_busy && tx_sel != $past(tx_sel)));

   assert_rx_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_start && !rx_busy) |=> (rx_busy && rx_sel != $past(rx_sel)));

   assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_start && !tx_busy) |=> $stable(tx_sel));

   assert_rx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_start && !rx_busy) |=> $stable(rx_sel));

   assert_tx_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_start && tx_busy) |=> tx_overrun);

   assert_rx_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_start && rx_busy) |=> rx_overrun);

   assert_tx_no_ovr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_start && tx_busy) |=> !tx_overrun);

   assert_tx_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done && tx_busy) |=> !tx_busy);

   assert_rx_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && rx_busy) |=> !rx_busy);

   assert_status_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (status[3] == tx_sel && status[2] == tx_busy &&
       status[1] == rx_sel && status[0] == rx_busy));

   assert_status_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((status >> 4) == '0));

endmodule

bind pingpong_buf_sel pingpong_buf_sel_chk #(.STATUS_W(STATUS_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_start   (tx_start),
   .tx_done    (tx_done),
   .rx_start   (rx_start),
   .rx_done    (rx_done),
   .tx_sel     (tx_sel),
   .tx_busy    (tx_busy),
   .tx_overrun (tx_overrun),
   .rx_sel     (rx_sel),
   .rx_busy    (rx_busy),
   .rx_overrun (rx_overrun),
   .status     (status)
);

// File: tb/pingpong_buf_sel_bench.sv
module pingpong_buf_sel_bench;

   localparam int CLK_PERIOD = 10;
   localparam int STATUS_W   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_start = 1'b0, tx_done = 1'b0, rx_start = 1'b0, rx_done = 1'b0;
   logic tx_sel, tx_busy, tx_overrun, rx_sel, rx_busy, rx_overrun;
   logic [STATUS_W-1:0] status;

   int checks = 0;
   int errors = 0;

   // Reference model state: index 0 = receive, 1 = transmit.
   int m_next [2];
   int m_busy [2];
   int m_ovr  [2];

   always #(CLK_PERIOD/2) clk = ~clk;

   pingpong_buf_sel #(.STATUS_W(STATUS_W)) u_pingpong_buf_sel (
      .clk(clk), .rst_n(rst_n),
      .tx_start(tx_start), .tx_done(tx_done),
      .rx_start(rx_start), .rx_done(rx_done),
      .tx_sel(tx_sel), .tx_busy(tx_busy), .tx_overrun(tx_overrun),
      .rx_sel(rx_sel), .rx_busy(rx_busy), .rx_overrun(rx_overrun),
      .status(status)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare_all(input string tag);
      int exp_status;
      exp_status = m_next[1]*8 + m_busy[1]*4 + m_next[0]*2 + m_busy[0];
      check(tag, "tx_sel",     int'(tx_sel),     m_next[1]);
      check(tag, "rx_sel",     int'(rx_sel),     m_next[0]);
      check(tag, "tx_busy",    int'(tx_busy),    m_busy[1]);
      check(tag, "rx_busy",    int'(rx_busy),    m_busy[0]);
      check(tag, "tx_overrun", int'(tx_overrun), m_ovr[1]);
      check(tag, "rx_overrun", int'(rx_overrun), m_ovr[0]);
      check("R6", "status",    int'(status),     exp_status);
   endtask

   task automatic model_reset();
      for (int i = 0; i < 2; i++) begin
         m_next[i] = 0; m_busy[i] = 0; m_ovr[i] = 0;
      end
   endtask

   task automatic model_step(input int i, input int st, input int dn);
      if (st != 0 && m_busy[i] == 0) begin
         m_next[i] = 1 - m_next[i];
         m_busy[i] = 1;
         m_ovr[i]  = 0;
      end else if (st != 0) begin
         m_ovr[i]  = 1;
         if (dn != 0) m_busy[i] = 0;
      end else begin
         m_ovr[i]  = 0;
         if (dn != 0) m_busy[i] = 0;
      end
   endtask

   // One cycle: drive at negedge, advance model, then check at next negedge.
   task automatic cycle(input string tag, input logic ts, input logic td,
                        input logic rs, input logic rd);
      tx_start = ts; tx_done = td; rx_start = rs; rx_done = rd;
      model_step(1, int'(ts), int'(td));
      model_step(0, int'(rs), int'(rd));
      @(negedge clk);
      compare_all(tag);
   endtask

   initial begin
      #(CLK_PERIOD*100000);
      errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      model_reset();
      repeat (3) @(negedge clk);
      compare_all("R1");
      rst_n = 1'b1;
      @(negedge clk);
      compare_all("R1");

      // R3: accepted start toggles select to B and sets busy
      cycle("R3", 1, 0, 0, 0);
      cycle("R3", 0, 0, 0, 0);
      // R5: start while busy is refused and flags overrun for one cycle
      cycle("R5", 1, 0, 0, 0);
      cycle("R5", 0, 0, 0, 0);
      // R4: done clears busy, select kept
      cycle("R4", 0, 1, 0, 0);
      // R9: done while idle changes nothing
      cycle("R9", 0, 1, 0, 1);
      cycle("R9", 0, 0, 0, 0);
      // R8: busy start+done -> clear and overrun; idle start+done -> accept
      cycle("R8", 1, 0, 0, 0);
      cycle("R8", 1, 1, 0, 0);
      cycle("R8", 1, 1, 0, 0);
      cycle("R8", 0, 1, 0, 0);
      // R7: receive activity leaves transmit untouched, and the reverse
      cycle("R7", 0, 0, 1, 0);
      cycle("R7", 0, 0, 1, 0);
      cycle("R7", 1, 0, 0, 1);
      cycle("R7", 0, 1, 0, 0);

      // R2: mixed traffic compared against the model every cycle
      lfsr = 16'hACE1;
      for (int n = 0; n < 400; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cycle("R2", lfsr[0] & lfsr[3], lfsr[5], lfsr[7] & lfsr[9], lfsr[11]);
      end

      // R1: reset in mid-traffic returns everything to buffer A
      cycle("R1", 1, 0, 1, 0);
      rst_n = 1'b0;
      tx_start = 0; tx_done = 0; rx_start = 0; rx_done = 0;
      model_reset();
      @(negedge clk);
      compare_all("R1");
      rst_n = 1'b1;
      @(negedge clk);
      compare_all("R1");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule